// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policy

This block is a single-level, direct-mapped cache. It sits between a CPU that issues single-word reads and writes and a slower word-wide main memory. Each CPU word address is split into three fields. The upper bits form a tag, the middle bits form a line index, and the low bits select a word inside a multi-word line. Every line keeps a stored tag, a valid flag, a dirty flag (write-back only) and a block of data words.

A build-time parameter selects the write policy:

- **Write-back.** Writes stay in the cache and mark the line dirty. A dirty line is copied out to memory before it is replaced. A write miss first refills the line and then writes into it.
- **Write-through.** Every write goes to memory as one word transfer, and the cache copy is updated on a hit. A write miss does not allocate a line.

A read miss refills the whole line from memory, one word per handshake, in ascending word order.

The CPU raises `cpu_req` and holds it, together with `cpu_we`, `cpu_addr` and `cpu_wdata`, stable until `cpu_ack` is high at a clock edge. For read requests, `cpu_rdata` is valid in that same cycle. The memory side uses a request/acknowledge handshake: one word moves in each cycle where `mem_req` and `mem_ack` are both high.

Top module: `line_cache`

## Requirements
- R1: The address is split as tag = addr[15:10], index = addr[9:4], word offset = addr[3:0]. A request hits only when the indexed line is valid and its stored tag equals the address tag. A read hit or a write-back write hit raises `cpu_ack` in the first cycle the request is seen, with no memory transfer. A read hit returns the cached word.
- R2: A read miss performs exactly 16 memory reads at addresses {tag, index, 0} through {tag, index, 15} in ascending order. `cpu_ready` stays low while this runs. The request is then acknowledged with the word the memory held, or the latest word written by the CPU.
- R3: In write-back mode, a write hit causes no memory transfer, updates the cached word and marks the line dirty.
- R4: In write-back mode, a miss on a valid dirty line first performs 16 memory writes of that line's words at {old tag, index, 0..15}, in ascending order, and then refills. A miss on a clean or invalid line performs no memory write.
- R5: In write-back mode, a write miss refills the line with 16 reads, then acknowledges and stores the CPU word. It performs no memory write.
- R6: In write-through mode, each CPU write performs exactly one memory write of `cpu_wdata` at `cpu_addr`. `cpu_ack` is raised in the same cycle as that transfer's `mem_ack`. On a hit, the cached copy is updated as well.
- R7: In write-through mode, a write miss does not allocate a line, so a later read of the same word misses and refills.
- R8: Reset clears every valid and dirty flag. After reset, each access misses, and data written but never copied to memory before reset is not written back.
- R9: Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle with `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address {tag, index, offset} |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ack` is high on a read |
| cpu_ready | output | 1 | High when the controller is idle and can serve a hit at once |
| cpu_ack | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer completes at this clock edge |

## Verification
Two instances run side by side, one per write policy, each with a behavioural model of the memory and the cache lines.

- **Directed sequences.** These separate a read hit from a read miss on an empty line, and a write hit from a write miss. They also separate a clean replacement from a dirty one on the same index. Comparing these cases shows whether the eviction traffic, the allocation on a write miss and the write-through forwarding appear only where the policy calls for them.
- **Pseudo-random mix.** A mix of reads and writes is confined to four tags and four indices, which forces frequent conflicts. It exposes wrong victim data, wrong transfer order and stale data after replacement.
- **Reset test.** A reset taken while lines are dirty confirms that no write-back follows it.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } lc_state_e;
endpackage

// File: rtl/lc_tag_store.sv
`timescale 1ns/1ps
module lc_tag_store #(
  parameter int TAG_W      = 6,
  parameter int IDX_W      = 6,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] line_tag,
  output logic             line_valid,
  output logic             line_dirty,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign line_tag   = tag_q[idx];
  assign line_valid = valid_q[idx];

  generate
    if (WRITE_BACK) begin : g_dirty
      logic [LINES-1:0] dirty_q, dirty_d;

      always_comb begin
        dirty_d = dirty_q;
        if (fill_en)       dirty_d[idx] = 1'b0;
        else if (dirty_en) dirty_d[idx] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dirty_q <= '0;
        else        dirty_q <= dirty_d;
      end

      assign line_dirty = dirty_q[idx];

      // R3
      dirty_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_en |=> line_dirty);
    end else begin : g_clean
      assign line_dirty = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lc_data_store.sv
`timescale 1ns/1ps
module lc_data_store #(
  parameter int DATA_W = 16,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/lc_ctrl.sv
`timescale 1ns/1ps
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int TAG_W      = 6,
  parameter int IDX_W      = 6,
  parameter int OFF_W      = 4,
  parameter int DATA_W     = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [TAG_W-1:0]              cpu_tag,
  input  logic [IDX_W-1:0]              cpu_idx,
  input  logic [OFF_W-1:0]              cpu_off,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic                          cpu_ready,
  output logic                          cpu_ack,
  input  logic                          hit,
  input  logic                          line_valid,
  input  logic                          line_dirty,
  input  logic [TAG_W-1:0]              line_tag,
  input  logic [DATA_W-1:0]             line_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata,
  input  logic                          mem_ack,
  output logic                          data_we,
  output logic [OFF_W-1:0]              data_woff,
  output logic [DATA_W-1:0]             data_wdata,
  output logic [OFF_W-1:0]              data_roff,
  output logic                          fill_en,
  output logic                          dirty_en
);
  lc_state_e        state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last_word;

  assign last_word = (cnt_q == {OFF_W{1'b1}});

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    cpu_ack    = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {cpu_tag, cpu_idx, cpu_off};
    mem_wdata  = cpu_wdata;
    data_we    = 1'b0;
    data_woff  = cpu_off;
    data_wdata = cpu_wdata;
    data_roff  = cpu_off;
    fill_en    = 1'b0;
    dirty_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (WRITE_BACK) begin
            if (hit) begin
              cpu_ack = 1'b1;
              if (cpu_we) begin
                data_we  = 1'b1;
                dirty_en = 1'b1;
              end
            end else begin
              cnt_en  = 1'b1;
              cnt_d   = '0;
              state_d = (line_valid && line_dirty) ? ST_EVICT : ST_FILL;
            end
          end else begin
            if (cpu_we) begin
              state_d = ST_WTHRU;
            end else if (hit) begin
              cpu_ack = 1'b1;
            end else begin
              cnt_en  = 1'b1;
              cnt_d   = '0;
              state_d = ST_FILL;
            end
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        data_roff = cnt_q;
        mem_addr  = {line_tag, cpu_idx, cnt_q};
        mem_wdata = line_rdata;
        if (mem_ack) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (last_word) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req    = 1'b1;
        mem_addr   = {cpu_tag, cpu_idx, cnt_q};
        data_woff  = cnt_q;
        data_wdata = mem_rdata;
        if (mem_ack) begin
          data_we = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (last_word) begin
            fill_en = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ack = 1'b1;
          data_we = hit;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cpu_ready = (state_q == ST_IDLE);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  evict_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT) |-> (line_valid && line_dirty));

  generate
    if (WRITE_BACK) begin : g_wb_chk
      // R3
      wb_write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_we) |-> !mem_req);
    end else begin : g_wt_chk
      // R6
      wt_write_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_we) |-> (mem_ack && mem_we && mem_wdata == cpu_wdata));
    end
  endgenerate
endmodule

// File: rtl/line_cache.sv
`timescale 1ns/1ps
module line_cache #(
  parameter int TAG_W      = 6,
  parameter int IDX_W      = 6,
  parameter int OFF_W      = 4,
  parameter int DATA_W     = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_ready,
  output logic                          cpu_ack,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata,
  input  logic                          mem_ack
);
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
  localparam int DAW    = IDX_W + OFF_W;

  logic             rst_s0_q, rst_s1_q, rst_int_n;
  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic [OFF_W-1:0] cpu_off;
  logic [TAG_W-1:0] line_tag;
  logic             line_valid, line_dirty, hit;
  logic             fill_en, dirty_en, data_we;
  logic [OFF_W-1:0] data_woff, data_roff;
  logic [DATA_W-1:0] data_wdata, line_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_int_n = rst_s1_q;

  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign hit     = line_valid && (line_tag == cpu_tag);

  lc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WRITE_BACK(WRITE_BACK)) u_tags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idx        (cpu_idx),
    .line_tag   (line_tag),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .fill_en    (fill_en),
    .fill_tag   (cpu_tag),
    .dirty_en   (dirty_en)
  );

  lc_data_store #(.DATA_W(DATA_W), .AW(DAW)) u_data (
    .clk   (clk),
    .we    (data_we),
    .waddr ({cpu_idx, data_woff}),
    .wdata (data_wdata),
    .raddr ({cpu_idx, data_roff}),
    .rdata (line_rdata)
  );

  lc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
            .WRITE_BACK(WRITE_BACK)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_tag    (cpu_tag),
    .cpu_idx    (cpu_idx),
    .cpu_off    (cpu_off),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_ack    (cpu_ack),
    .hit        (hit),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .line_rdata (line_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .data_we    (data_we),
    .data_woff  (data_woff),
    .data_wdata (data_wdata),
    .data_roff  (data_roff),
    .fill_en    (fill_en),
    .dirty_en   (dirty_en)
  );

  assign cpu_rdata = line_rdata;

  // R2
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fill_en |=> hit);
endmodule

// File: tb/line_cache_tb_top.sv
`timescale 1ns/1ps
module line_cache_tb_top;
  localparam int MEM_LAT = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic        cpu_req [2];
  logic        cpu_we  [2];
  logic [15:0] cpu_addr [2];
  logic [15:0] cpu_wdata [2];
  logic [15:0] cpu_rdata [2];
  logic        cpu_ready [2];
  logic        cpu_ack [2];
  logic        mem_req [2];
  logic        mem_we  [2];
  logic [15:0] mem_addr [2];
  logic [15:0] mem_wdata [2];
  logic [15:0] mem_rdata [2];
  logic        mem_ack [2];

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [15:0] bmem [int];
  logic [15:0] golden [int];
  logic [5:0]  mtag [2][64];
  bit          mval [2][64];
  bit          mdirty [2][64];
  int          lat_cnt [2];

  bit          q_we [$];
  logic [15:0] q_addr [$];
  logic [15:0] q_dat [$];

  always #5 clk = ~clk;

  for (genvar g = 0; g < 2; g++) begin : g_dut
    line_cache #(.WRITE_BACK(g == 0)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req[g]),
      .cpu_we    (cpu_we[g]),
      .cpu_addr  (cpu_addr[g]),
      .cpu_wdata (cpu_wdata[g]),
      .cpu_rdata (cpu_rdata[g]),
      .cpu_ready (cpu_ready[g]),
      .cpu_ack   (cpu_ack[g]),
      .mem_req   (mem_req[g]),
      .mem_we    (mem_we[g]),
      .mem_addr  (mem_addr[g]),
      .mem_wdata (mem_wdata[g]),
      .mem_rdata (mem_rdata[g]),
      .mem_ack   (mem_ack[g])
    );
  end

  function automatic int key(int d, logic [15:0] a);
    return d * 65536 + int'({16'd0, a});
  endfunction

  function automatic logic [15:0] init_val(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h1357;
  endfunction

  function automatic logic [15:0] mem_val(int d, logic [15:0] a);
    if (bmem.exists(key(d, a))) return bmem[key(d, a)];
    return init_val(a);
  endfunction

  function automatic logic [15:0] gval(int d, logic [15:0] a);
    if (golden.exists(key(d, a))) return golden[key(d, a)];
    return mem_val(d, a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Memory responder: one word per acknowledge, MEM_LAT idle cycles first
  initial begin
    for (int d = 0; d < 2; d++) begin
      mem_ack[d]   = 1'b0;
      mem_rdata[d] = '0;
      lat_cnt[d]   = 0;
    end
    forever begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        if (mem_ack[d]) begin
          mem_ack[d] = 1'b0;
        end else if (mem_req[d] === 1'b1) begin
          if (lat_cnt[d] >= MEM_LAT) begin
            lat_cnt[d] = 0;
            mem_ack[d] = 1'b1;
            if (mem_we[d]) bmem[key(d, mem_addr[d])] = mem_wdata[d];
            else           mem_rdata[d] = mem_val(d, mem_addr[d]);
          end else begin
            lat_cnt[d]++;
          end
        end
      end
    end
  end

  task automatic push_exp(input bit we, input logic [15:0] a, input logic [15:0] dat);
    q_we.push_back(we);
    q_addr.push_back(a);
    q_dat.push_back(dat);
  endtask

  task automatic do_op(input int d, input bit we, input logic [15:0] a,
                       input logic [15:0] wd, input string rq);
    int          ix;
    logic [5:0]  tg;
    bit          hit;
    bit          imm;
    bit          first;
    bit          got;
    int          ncyc;
    logic [15:0] exp_rd;
    bit          p_req;
    bit          p_ack;
    logic [15:0] p_addr;
    bit          e_we;
    logic [15:0] e_addr;
    logic [15:0] e_dat;

    q_we.delete(); q_addr.delete(); q_dat.delete();
    ix  = int'(a[9:4]);
    tg  = a[15:10];
    hit = mval[d][ix] && (mtag[d][ix] == tg);
    if (d == 0) begin
      if (!hit) begin
        if (mval[d][ix] && mdirty[d][ix])
          for (int k = 0; k < 16; k++)
            push_exp(1'b1, {mtag[d][ix], a[9:4], 4'(k)}, gval(d, {mtag[d][ix], a[9:4], 4'(k)}));
        for (int k = 0; k < 16; k++) push_exp(1'b0, {tg, a[9:4], 4'(k)}, 16'h0);
        mval[d][ix] = 1'b1; mtag[d][ix] = tg; mdirty[d][ix] = 1'b0;
      end
      if (we) mdirty[d][ix] = 1'b1;
    end else begin
      if (we) push_exp(1'b1, a, wd);
      else if (!hit) begin
        for (int k = 0; k < 16; k++) push_exp(1'b0, {tg, a[9:4], 4'(k)}, 16'h0);
        mval[d][ix] = 1'b1; mtag[d][ix] = tg;
      end
    end
    exp_rd = gval(d, a);
    if (we) golden[key(d, a)] = wd;
    imm = (q_we.size() == 0);

    @(negedge clk);
    cpu_req[d] = 1'b1; cpu_we[d] = we; cpu_addr[d] = a; cpu_wdata[d] = wd;
    first = 1'b1; got = 1'b0; ncyc = 0; p_req = 1'b0; p_ack = 1'b0; p_addr = '0;
    while (!got) begin
      #4;
      if (p_req && !p_ack)
        chk(mem_req[d] === 1'b1 && mem_addr[d] === p_addr, "R9", "request hold",
            int'({mem_req[d], mem_addr[d]}), int'({1'b1, p_addr}));
      p_req = mem_req[d]; p_ack = mem_ack[d]; p_addr = mem_addr[d];
      if (mem_ack[d] === 1'b1) begin
        if (q_we.size() == 0) begin
          chk(1'b0, rq, "unexpected memory transfer", int'(mem_addr[d]), 0);
        end else begin
          e_we = q_we.pop_front(); e_addr = q_addr.pop_front(); e_dat = q_dat.pop_front();
          chk(mem_we[d] === e_we && mem_addr[d] === e_addr, rq, "transfer kind/address",
              int'({mem_we[d], mem_addr[d]}), int'({e_we, e_addr}));
          if (e_we)
            chk(mem_wdata[d] === e_dat, rq, "memory write data",
                int'(mem_wdata[d]), int'(e_dat));
        end
      end
      if (!first && q_we.size() > 0)
        chk(cpu_ready[d] === 1'b0, "R2", "ready low while busy", int'(cpu_ready[d]), 0);
      if (cpu_ack[d] === 1'b1) begin
        got = 1'b1;
        chk(q_we.size() == 0, rq, "transfers left at acknowledge", q_we.size(), 0);
        if (!we) chk(cpu_rdata[d] === exp_rd, rq, "read data", int'(cpu_rdata[d]), int'(exp_rd));
      end else if (first && imm) begin
        chk(1'b0, "R1", "hit not acknowledged at once", 0, 1);
      end
      first = 1'b0;
      ncyc++;
      if (ncyc > 300) begin
        chk(1'b0, rq, "request timeout", ncyc, 300);
        got = 1'b1;
      end
      @(negedge clk);
    end
    cpu_req[d] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int d = 0; d < 2; d++) cpu_req[d] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 64; i++) begin
        mval[d][i] = 1'b0; mdirty[d][i] = 1'b0;
      end
    golden.delete();
    #4;
    for (int d = 0; d < 2; d++) begin
      chk(cpu_ready[d] === 1'b1, "R8", "ready after reset", int'(cpu_ready[d]), 1);
      chk(mem_req[d] === 1'b0, "R8", "no memory request after reset", int'(mem_req[d]), 0);
      chk(cpu_ack[d] === 1'b0, "R8", "no acknowledge after reset", int'(cpu_ack[d]), 0);
    end
  endtask

  task automatic random_mix(input int d, input int n, input logic [31:0] seed);
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < n; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      do_op(d, s[24], {4'd0, s[9:8], 4'd0, s[11:10], s[15:12]}, s[31:16], "R4");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      cpu_req[d] = 1'b0; cpu_we[d] = 1'b0; cpu_addr[d] = '0; cpu_wdata[d] = '0;
    end
    do_reset();

    // write-back instance
    do_op(0, 1'b0, 16'h0123, 16'h0, "R2");
    do_op(0, 1'b0, 16'h0125, 16'h0, "R1");
    do_op(0, 1'b1, 16'h0125, 16'hBEEF, "R3");
    do_op(0, 1'b0, 16'h0125, 16'h0, "R3");
    do_op(0, 1'b0, 16'h0523, 16'h0, "R4");
    do_op(0, 1'b0, 16'h0125, 16'h0, "R4");
    do_op(0, 1'b1, 16'h2A07, 16'h1234, "R5");
    do_op(0, 1'b0, 16'h2A07, 16'h0, "R5");
    random_mix(0, 160, 32'h1234_5678);
    do_op(0, 1'b1, 16'h3456, 16'h1111, "R8");
    do_reset();
    do_op(0, 1'b0, 16'h3456, 16'h0, "R8");
    do_op(0, 1'b0, 16'h2A07, 16'h0, "R8");

    // write-through instance
    do_op(1, 1'b0, 16'h0123, 16'h0, "R2");
    do_op(1, 1'b0, 16'h012F, 16'h0, "R1");
    do_op(1, 1'b1, 16'h0125, 16'hCAFE, "R6");
    do_op(1, 1'b0, 16'h0125, 16'h0, "R6");
    do_op(1, 1'b1, 16'h4C31, 16'h7777, "R7");
    do_op(1, 1'b0, 16'h4C31, 16'h0, "R7");
    random_mix(1, 160, 32'h0BAD_F00D);

    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule